// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects up to 63 peripheral interrupt request lines and ranks them in two tiers. Each source carries its own configuration: a 3-bit level from 1 to 7, where 0 switches the source off, and a rank inside that level. The controller tells the processor which level is pending by driving a 3-bit level code. It drives that code only when the level is above the processor's current mask. Level 7 is always presented and cannot be masked.

The controller answers an interrupt-acknowledge cycle on its own and does not address the peripheral. When the processor strobes an acknowledge and names a level, the controller returns an 8-bit vector. The vector is 64 plus the source index of the winner at that level. If nothing is pending at that level, the vector is 24, the spurious vector. An acknowledge leaves the request untouched. The service routine must clear the request in the peripheral, and the source stays pending until its line drops.

Arbitration is registered. One stage holds the winner of each level, and a second stage holds the level code. The vector register captures its value at the edge where the acknowledge is seen.

Top module: `irq_ctrl`

## Requirements
- R1: After reset `ipl_o` is 0 and `vec_valid_o` is 0.
- R2: `ipl_o` shows the highest level among the active requests two clock edges after the request inputs change. A request is active when its line is high and its level field is nonzero. The level field of source i is `cfg_level_i[3*i+2:3*i]`.
- R3: A level from 1 to 6 appears on `ipl_o` only if it is strictly greater than `cpu_mask_i`. A level equal to or below the mask gives `ipl_o` = 0.
- R4: Level 7 appears on `ipl_o` whatever the value of `cpu_mask_i`, including a mask of 7.
- R5: A source whose level field is 0 is ignored, both for `ipl_o` and for vectors.
- R6: Within one level, the source with the largest rank wins. The rank of source i is `cfg_rank_i[4*i+3:4*i]`. When ranks are equal, the lower source index wins.
- R7: An acknowledge (`ack_i` high at a clock edge) drives `vec_valid_o` high for the following cycle. In that cycle `vec_o` is 64 plus the winning source index at `ack_level_i`. `vec_valid_o` returns to 0 after a cycle with no acknowledge.
- R8: If no active request exists at the acknowledged level, `vec_o` is 24. This includes an acknowledge of level 0.
- R9: An acknowledge does not clear any request. `ipl_o` stays asserted afterwards, and a repeated acknowledge returns the same vector.
- R10: A request is pending until its line drops. After that, the next-ranked source at the level wins, or `ipl_o` falls to 0 when none remains.
- R11: The vector comes from the acknowledged level, not from the highest pending level.
- R12: A request line that drops in the same cycle as an acknowledge is still reported by that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | 63 | Request line of each source |
| cfg_level_i | input | 189 | Level of each source, 3 bits per source, 0 = off |
| cfg_rank_i | input | 252 | Rank of each source within its level, 4 bits per source |
| cpu_mask_i | input | 3 | Processor's current interrupt mask |
| ack_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Level code presented to the processor, 0 = none |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | High in the cycle after an acknowledge |

## Verification
An acknowledge and a change on a request line can land in the same cycle. The acknowledge reads the registered winner, while the dropped line only reaches that register at the same edge. The bench provokes this by lowering the winning request and raising `ack_i` in one drive slot. It then expects the vector of the source that just dropped. On the acknowledge that follows, it expects the next-ranked source or the spurious vector. A second overlap is an acknowledge of a low level while a higher level is pending. In that case the vector must come from the lower level while `ipl_o` keeps showing the higher one.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 64;
  localparam int VEC_SPUR = 24;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_lvl_arb.sv
// Winner of one level: highest rank, lowest index on a tie. Registered.
module irq_lvl_arb
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int RANK_W  = 4,
  parameter int LEVEL   = 1,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*LVL_W-1:0]  lvl_i,
  input  logic [NUM_SRC*RANK_W-1:0] rank_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic              hit_d, hit_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [RANK_W-1:0] best_d;

  always_comb begin
    hit_d  = 1'b0;
    idx_d  = '0;
    best_d = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (req_i[s] && (lvl_i[s*LVL_W +: LVL_W] == LVL_W'(LEVEL))) begin
        if (!hit_d || (rank_i[s*RANK_W +: RANK_W] > best_d)) begin
          hit_d  = 1'b1;
          idx_d  = IDX_W'(s);
          best_d = rank_i[s*RANK_W +: RANK_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      idx_q <= idx_d;
    end
  end

  assign hit_o = hit_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/irq_lvl_pick.sv
// Highest pending level, gated by the processor mask; top level never masked.
module irq_lvl_pick
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 7
) (
  input  logic [NUM_LVL-1:0] hit_i,
  input  lvl_t               mask_i,
  output lvl_t               ipl_o
);
  lvl_t top;

  always_comb begin
    top = '0;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (hit_i[l-1]) top = LVL_W'(l);
    end
    if ((top == LVL_W'(NUM_LVL)) || (top > mask_i)) ipl_o = top;
    else                                              ipl_o = '0;
  end
endmodule

// File: rtl/irq_vec_gen.sv
// Vector for an acknowledged level: base plus winner index, or spurious.
module irq_vec_gen
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LVL = 7,
  parameter int IDX_W   = 6
) (
  input  logic [NUM_LVL-1:0]       hit_i,
  input  logic [NUM_LVL*IDX_W-1:0] idx_i,
  input  lvl_t                     ack_lvl_i,
  output vec_t                     vec_o
);
  always_comb begin
    vec_o = VEC_W'(VEC_SPUR);
    for (int l = 1; l <= NUM_LVL; l++) begin
      if ((ack_lvl_i == LVL_W'(l)) && hit_i[l-1]) begin
        vec_o = VEC_W'(VEC_BASE) + VEC_W'(idx_i[(l-1)*IDX_W +: IDX_W]);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int NUM_LVL = 7,
  parameter int RANK_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        irq_req_i,
  input  logic [NUM_SRC*3-1:0]      cfg_level_i,
  input  logic [NUM_SRC*RANK_W-1:0] cfg_rank_i,
  input  logic [2:0]                cpu_mask_i,
  input  logic                      ack_i,
  input  logic [2:0]                ack_level_i,
  output logic [2:0]                ipl_o,
  output logic [7:0]                vec_o,
  output logic                      vec_valid_o
);
  logic [1:0]               rst_sync_q;
  logic                     rst_n_q;
  logic [NUM_LVL-1:0]       hit;
  logic [NUM_LVL*IDX_W-1:0] idx_all;
  lvl_t                     ipl_d, ipl_q;
  vec_t                     vec_d, vec_q;
  logic                     vval_q;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    irq_lvl_arb #(
      .NUM_SRC(NUM_SRC), .RANK_W(RANK_W), .LEVEL(g + 1)
    ) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_n_q),
      .req_i (irq_req_i),
      .lvl_i (cfg_level_i),
      .rank_i(cfg_rank_i),
      .hit_o (hit[g]),
      .idx_o (idx_all[g*IDX_W +: IDX_W])
    );
  end

  irq_lvl_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .hit_i (hit),
    .mask_i(cpu_mask_i),
    .ipl_o (ipl_d)
  );

  irq_vec_gen #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_vec (
    .hit_i    (hit),
    .idx_i    (idx_all),
    .ack_lvl_i(ack_level_i),
    .vec_o    (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      ipl_q  <= '0;
      vval_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      ipl_q  <= ipl_d;
      vval_q <= ack_i;
      if (ack_i) vec_q <= vec_d;
    end
  end

  assign ipl_o       = ipl_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vval_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 63
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_req_i,
  input logic [2:0]         cpu_mask_i,
  input logic               ack_i,
  input logic [2:0]         ipl_o,
  input logic [7:0]         vec_o,
  input logic               vec_valid_o
);
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o == 8'd24) ||
                    ((vec_o >= 8'd64) && (vec_o < 8'(64 + NUM_SRC)))); // R7

  AST_ACK_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o); // R7

  AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_valid_o); // R7

  AST_MASK_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ipl_o != 3'd0) && (ipl_o != 3'd7)) |-> (ipl_o > $past(cpu_mask_i))); // R3

  AST_IDLE_NO_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_req_i == '0) && $past(irq_req_i == '0, 2)) |-> (ipl_o == 3'd0)); // R2
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_q),
  .irq_req_i  (irq_req_i),
  .cpu_mask_i (cpu_mask_i),
  .ack_i      (ack_i),
  .ipl_o      (ipl_o),
  .vec_o      (vec_o),
  .vec_valid_o(vec_valid_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int NS = 63;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [NS-1:0] irq_req_i;
  logic [NS*3-1:0] cfg_level_i;
  logic [NS*4-1:0] cfg_rank_i;
  logic [2:0]    cpu_mask_i;
  logic          ack_i;
  logic [2:0]    ack_level_i;
  logic [2:0]    ipl_o;
  logic [7:0]    vec_o;
  logic          vec_valid_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i),
    .cfg_level_i(cfg_level_i), .cfg_rank_i(cfg_rank_i),
    .cpu_mask_i(cpu_mask_i), .ack_i(ack_i), .ack_level_i(ack_level_i),
    .ipl_o(ipl_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(int s, int lvl, int rank);
    cfg_level_i[s*3 +: 3] = 3'(lvl);
    cfg_rank_i[s*4 +: 4]  = 4'(rank);
  endtask

  task automatic clear_all();
    irq_req_i = '0; cfg_level_i = '0; cfg_rank_i = '0;
    cpu_mask_i = 3'd0; ack_i = 1'b0; ack_level_i = 3'd0;
    tick(2);
  endtask

  // ack at next edge; vec seen in the following cycle
  task automatic do_ack(int lvl, string req, int exp);
    ack_i = 1'b1; ack_level_i = 3'(lvl);
    tick();
    ack_i = 1'b0;
    chk(req, int'(vec_valid_o), 1);
    chk(req, int'(vec_o), exp);
    tick();
    chk(req, int'(vec_valid_o), 0);
  endtask

  task automatic t_reset();
    chk("R1", int'(ipl_o), 0);
    chk("R1", int'(vec_valid_o), 0);
  endtask

  task automatic t_level();
    clear_all();
    cfg(5, 3, 2); irq_req_i[5] = 1'b1;
    tick(2); chk("R2", int'(ipl_o), 3);
    cfg(10, 5, 0); irq_req_i[10] = 1'b1;
    tick(2); chk("R2", int'(ipl_o), 5);
  endtask

  task automatic t_mask();
    clear_all();
    cfg(10, 5, 0); irq_req_i[10] = 1'b1;
    cpu_mask_i = 3'd5; tick(2); chk("R3", int'(ipl_o), 0);
    cpu_mask_i = 3'd4; tick();  chk("R3", int'(ipl_o), 5);
    cpu_mask_i = 3'd6; tick();  chk("R3", int'(ipl_o), 0);
  endtask

  task automatic t_nmi();
    clear_all();
    cfg(20, 7, 0); irq_req_i[20] = 1'b1; cpu_mask_i = 3'd7;
    tick(2); chk("R4", int'(ipl_o), 7);
    do_ack(7, "R4", 84);
  endtask

  task automatic t_disable();
    clear_all();
    cfg(30, 0, 9); irq_req_i[30] = 1'b1;
    tick(2); chk("R5", int'(ipl_o), 0);
    do_ack(0, "R5", 24);
  endtask

  task automatic t_rank();
    clear_all();
    cfg(3, 4, 1); cfg(40, 4, 6);
    irq_req_i[3] = 1'b1; irq_req_i[40] = 1'b1;
    tick(2); chk("R6", int'(ipl_o), 4);
    do_ack(4, "R6", 104);
    cfg(41, 4, 6); irq_req_i[41] = 1'b1;  // tie: lower index stays
    tick(2); do_ack(4, "R6", 104);
    // R9: request survives the acknowledge
    chk("R9", int'(ipl_o), 4);
    do_ack(4, "R9", 104);
    // R10: drop winners one by one
    irq_req_i[40] = 1'b0; tick(); do_ack(4, "R10", 105);
    irq_req_i[41] = 1'b0; tick(); do_ack(4, "R10", 67);
    irq_req_i[3]  = 1'b0; tick(2); chk("R10", int'(ipl_o), 0);
  endtask

  task automatic t_spurious();
    clear_all();
    cfg(7, 6, 0); irq_req_i[7] = 1'b1;
    tick(2);
    do_ack(2, "R8", 24);
  endtask

  task automatic t_acklevel();
    clear_all();
    cfg(7, 6, 0); cfg(50, 2, 3);
    irq_req_i[7] = 1'b1; irq_req_i[50] = 1'b1;
    tick(2);
    do_ack(2, "R11", 114);
    chk("R11", int'(ipl_o), 6);
  endtask

  task automatic t_same_cycle();
    clear_all();
    cfg(12, 3, 5); cfg(13, 3, 1);
    irq_req_i[12] = 1'b1; irq_req_i[13] = 1'b1;
    tick(2);
    irq_req_i[12] = 1'b0;
    do_ack(3, "R12", 76);
    do_ack(3, "R12", 77);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    irq_req_i = '0; cfg_level_i = '0; cfg_rank_i = '0;
    cpu_mask_i = 3'd0; ack_i = 1'b0; ack_level_i = 3'd0;
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    t_reset();
    t_level();
    t_mask();
    t_nmi();
    t_disable();
    t_rank();
    t_spurious();
    t_acklevel();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule